// File: doc/BRIEF.md
# Register-Programmed Serial Peripheral Master with Four-Byte Queues

This block is a full-duplex serial master that software drives through five small registers on a simple read/write bus. Software first puts the block into configuration mode, which lets it set the clock polarity, the clock phase, the bit order and the clock divisor. It then switches to run mode and writes bytes to the data register. Each byte enters a four-entry transmit queue, and a shift engine sends it on `mosi` while it captures one byte from `miso` into a four-entry receive queue. Software reads the received bytes back from the same data register. Chip-select is not part of this block; the system drives it separately.

A programmable receive fill level sets a status flag, and can also raise `irq`, when the receive queue holds at least that many bytes. This lets software send up to four bytes and then wait for the matching replies. Writing configuration mode together with the flush bit empties both queues. The same write clears the sticky overflow flag, which is set when software writes to a full transmit queue.

The shift engine is a four-state machine:
- **IDLE**: the clock is at its idle level. It moves to SETUP when run mode is on, the transmit queue has a byte and the receive queue has room, and it pops that byte.
- **SETUP**: one idle half-period. It moves to LEAD.
- **LEAD**: the clock is at its active level for one half-period. Entering LEAD is the leading edge. It moves to TRAIL.
- **TRAIL**: the clock is back at its idle level. Entering TRAIL is the trailing edge. After the eighth bit it moves to IDLE and pushes the received byte; otherwise it moves back to LEAD.

Leaving run mode forces the machine to IDLE from any state.

Top module: `spi_master_fifo`

Register addresses:
- 0, mode: bit0 is run (1) or configuration (0); bit1 is flush.
- 1, control A: bit0 clock polarity, bit1 phase, bit2 LSB-first, bit3 interrupt enable, bits[13:12] fill level minus one.
- 2, control B: bits[15:8] divisor n; bits[3:0] read as 8.
- 3, status: bit0 idle, bit1 fill reached, bit2 overflow, bit3 run.
- 4, data.

## Requirements
- R1: After reset the block is in configuration mode, status reads 16'h0001, `irq` is 0 and `sck` is 0.
- R2: Within a byte, each clock half-period lasts n+1 input clock cycles, where n is control B bits[15:8], so the `sck` period is 2*(n+1) cycles.
- R3: Whenever no byte is queued or in flight, `sck` sits at the polarity level set in control A bit0.
- R4: With phase (control A bit1) at 0, `miso` is sampled on the leading edge and `mosi` changes on the trailing edge. With phase at 1, `mosi` changes on the leading edge and `miso` is sampled on the trailing edge.
- R5: With control A bit2 set, bits go out and come in LSB first; otherwise they go MSB first.
- R6: Each byte written to address 4 in run mode is sent once, in order, and produces exactly one received byte, read back in order from address 4.
- R7: Status bit1 is 1 when the receive queue holds at least L+1 bytes, where L is control A bits[13:12]. `irq` equals status bit1 AND control A bit3.
- R8: Status bit0 is 1 only when the transmit queue is empty and no byte is shifting.
- R9: A data write while the transmit queue holds four bytes is dropped and sets status bit2. This bit stays set until it is flushed.
- R10: Writing the mode register with bit0=0 and bit1=1 empties both queues and clears status bit2.
- R11: In run mode, writes to control B and to the polarity, phase and order bits of control A are ignored. The enable and level fields stay writable. In configuration mode, data writes are ignored.
- R12: Between back-to-back bytes, `sck` stays idle for at least one half-period. The engine waits while the receive queue is full, so no received byte is lost.
- R13: Control B bits[3:0] always read 8, because the frame length is fixed at 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive queue at address 4) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the address |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Receive fill-level interrupt |

## Verification
The transmit queue can take a software push in the same cycle that the shift engine pops its head. The bench provokes this by writing six data words on consecutive cycles in run mode with the smallest divisor. It then judges the result by the count of bytes the serial-side model captures: exactly five, in write order. It also expects exactly one dropped word, seen as the overflow flag. The same burst fills the receive queue, so the bench also checks that the engine holds the fifth byte until software reads space free.

// File: rtl/spi_pkg.sv
`timescale 1ns/1ps
package spi_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LEAD,
        ST_TRAIL
    } shift_state_t;

    localparam logic [2:0] A_MODE   = 3'd0;
    localparam logic [2:0] A_CTRLA  = 3'd1;
    localparam logic [2:0] A_CTRLB  = 3'd2;
    localparam logic [2:0] A_STATUS = 3'd3;
    localparam logic [2:0] A_DATA   = 3'd4;
endpackage

// File: rtl/spi_fifo.sv
`timescale 1ns/1ps
module spi_fifo #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 8,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wp, rp;
    logic [CW-1:0]    cnt;
    logic             do_push, do_pop;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rp];
    assign count   = cnt;

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wp] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else if (clr) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= nxt(wp);
            if (do_pop)  rp <= nxt(rp);
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    // R9
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));
    // R9
    fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !clr) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/spi_shifter.sv
`timescale 1ns/1ps
module spi_shifter
    import spi_pkg::*;
#(
    parameter int DW   = 8,
    parameter int DIVW = 8,
    localparam int BCW = $clog2(DW + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic [DIVW-1:0] div,
    input  logic            cpol,
    input  logic            cpha,
    input  logic            lsb_first,
    input  logic            tx_valid,
    input  logic [DW-1:0]   tx_data,
    input  logic            rx_room,
    input  logic            miso,
    output logic            tx_pop,
    output logic            rx_push,
    output logic [DW-1:0]   rx_data,
    output logic            busy,
    output logic            sck,
    output logic            mosi
);
    shift_state_t    state, nxt_state;
    logic [DIVW-1:0] hc;
    logic [BCW-1:0]  bcnt;
    logic [DW-1:0]   tsh, rsh;
    logic            half_done, start, lead_edge, trail_edge, done;

    assign half_done  = (hc == div);
    assign start      = enable && (state == ST_IDLE) && tx_valid && rx_room;
    assign lead_edge  = enable && half_done &&
                        ((state == ST_SETUP) || (state == ST_TRAIL && bcnt != BCW'(DW)));
    assign trail_edge = enable && half_done && (state == ST_LEAD);
    assign done       = enable && half_done && (state == ST_TRAIL) && (bcnt == BCW'(DW));

    always_comb begin
        nxt_state = state;
        unique case (state)
            ST_IDLE:  if (start)     nxt_state = ST_SETUP;
            ST_SETUP: if (half_done) nxt_state = ST_LEAD;
            ST_LEAD:  if (half_done) nxt_state = ST_TRAIL;
            ST_TRAIL: if (half_done) nxt_state = (bcnt == BCW'(DW)) ? ST_IDLE : ST_LEAD;
        endcase
        if (!enable) nxt_state = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt_state;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hc   <= '0;
            bcnt <= '0;
            tsh  <= '0;
            rsh  <= '0;
        end else begin
            if (state == ST_IDLE || half_done || !enable) hc <= '0;
            else                                          hc <= hc + DIVW'(1);
            if (start) begin
                tsh  <= tx_data;
                bcnt <= '0;
            end
            if (lead_edge) begin
                if (cpha) begin
                    if (bcnt != '0) tsh <= lsb_first ? (tsh >> 1) : (tsh << 1);
                end else begin
                    rsh <= lsb_first ? {miso, rsh[DW-1:1]} : {rsh[DW-2:0], miso};
                end
            end
            if (trail_edge) begin
                if (cpha) begin
                    rsh <= lsb_first ? {miso, rsh[DW-1:1]} : {rsh[DW-2:0], miso};
                end else if (bcnt != BCW'(DW - 1)) begin
                    tsh <= lsb_first ? (tsh >> 1) : (tsh << 1);
                end
                bcnt <= bcnt + BCW'(1);
            end
        end
    end

    always_comb begin
        tx_pop  = start;
        rx_push = done;
        rx_data = rsh;
        busy    = (state != ST_IDLE);
        sck     = cpol ^ (state == ST_LEAD);
        mosi    = lsb_first ? tsh[0] : tsh[DW-1];
    end

    // R6
    bcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bcnt <= BCW'(DW));
    // R2
    half_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> (hc <= div));
    // R12
    rx_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> rx_room);
endmodule

// File: rtl/spi_master_fifo.sv
`timescale 1ns/1ps
module spi_master_fifo
    import spi_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int DW    = 8,
    parameter int DIVW  = 8,
    localparam int LW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [2:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        sck,
    output logic        mosi,
    input  logic        miso,
    output logic        irq
);
    logic            run, cpol, cpha, lsb, ie, ovf;
    logic [LW-1:0]   lvl;
    logic [DIVW-1:0] div;
    logic            wr_mode, wr_ctla, wr_ctlb, wr_data, rd_data, flush;
    logic            tx_full, tx_empty, rx_full, rx_empty, tx_pop, rx_push, busy, thr;
    logic [DW-1:0]   tx_head, rx_head, rx_word;
    logic [CW-1:0]   tx_cnt, rx_cnt;
    logic            unused_bits;

    assign unused_bits = ^{bus_wdata[7:4], tx_cnt};
    assign wr_mode = bus_wr && (bus_addr == A_MODE);
    assign wr_ctla = bus_wr && (bus_addr == A_CTRLA);
    assign wr_ctlb = bus_wr && (bus_addr == A_CTRLB);
    assign wr_data = bus_wr && (bus_addr == A_DATA);
    assign rd_data = bus_rd && (bus_addr == A_DATA);
    assign flush   = wr_mode && !bus_wdata[0] && bus_wdata[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run  <= 1'b0;
            cpol <= 1'b0;
            cpha <= 1'b0;
            lsb  <= 1'b0;
            ie   <= 1'b0;
            lvl  <= '0;
            div  <= '0;
            ovf  <= 1'b0;
        end else begin
            if (wr_mode) run <= bus_wdata[0];
            if (wr_ctla) begin
                ie  <= bus_wdata[3];
                lvl <= bus_wdata[12 +: LW];
                if (!run) begin
                    cpol <= bus_wdata[0];
                    cpha <= bus_wdata[1];
                    lsb  <= bus_wdata[2];
                end
            end
            if (wr_ctlb && !run) div <= bus_wdata[8 +: DIVW];
            if (flush)                          ovf <= 1'b0;
            else if (wr_data && run && tx_full) ovf <= 1'b1;
        end
    end

    spi_fifo #(.DEPTH(DEPTH), .WIDTH(DW)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(flush),
        .push(wr_data && run), .wdata(bus_wdata[DW-1:0]),
        .pop(tx_pop), .rdata(tx_head), .count(tx_cnt),
        .full(tx_full), .empty(tx_empty)
    );

    spi_fifo #(.DEPTH(DEPTH), .WIDTH(DW)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(flush),
        .push(rx_push), .wdata(rx_word),
        .pop(rd_data), .rdata(rx_head), .count(rx_cnt),
        .full(rx_full), .empty(rx_empty)
    );

    spi_shifter #(.DW(DW), .DIVW(DIVW)) u_shift (
        .clk(clk), .rst_n(rst_n), .enable(run), .div(div),
        .cpol(cpol), .cpha(cpha), .lsb_first(lsb),
        .tx_valid(!tx_empty), .tx_data(tx_head), .rx_room(!rx_full),
        .miso(miso), .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_word),
        .busy(busy), .sck(sck), .mosi(mosi)
    );

    assign thr = (rx_cnt >= (CW'(lvl) + CW'(1)));
    assign irq = ie && thr;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_MODE:   bus_rdata[0] = run;
            A_CTRLA:  begin
                bus_rdata[3:0]       = {ie, lsb, cpha, cpol};
                bus_rdata[12 +: LW]  = lvl;
            end
            A_CTRLB:  begin
                bus_rdata[8 +: DIVW] = div;
                bus_rdata[3:0]       = 4'(DW);
            end
            A_STATUS: bus_rdata[3:0] = {run, ovf, thr, tx_empty && !busy};
            A_DATA:   bus_rdata[DW-1:0] = rx_head;
            default:  bus_rdata = '0;
        endcase
    end

    // R11
    cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctlb && run) |=> $stable(div));
    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !flush) |=> ovf);
    // R7
    irq_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_empty |-> !irq);
    // R3
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (sck == cpol));
endmodule

// File: tb/tb_spi_master_fifo.sv
`timescale 1ns/1ps
module tb_spi_master_fifo;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        sck, mosi, irq;
    logic        miso = 1'b0;

    spi_master_fifo dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sck(sck), .mosi(mosi), .miso(miso), .irq(irq)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_fail = 0, mon_chk = 0, mon_fail = 0;
    int m_sent = 0, m_done = 0, m_div = 0;
    logic m_cpol = 0, m_cpha = 0, m_lsb = 0;
    logic [7:0] wb [0:127];
    logic [7:0] capt [0:127];
    bit finished = 0;

    function automatic logic [7:0] slv_byte(input int i);
        return 8'hA5 ^ 8'(i * 37);
    endfunction

    // Serial-side reference model: samples away from the clock edge.
    int cyc = 0, s_bit = 0, s_out = 0;
    logic prev_sck = 1'b0;
    logic [7:0] s_rx = '0;
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            int pend;
            logic lead;
            logic [7:0] tb;
            cyc++;
            pend = m_sent - m_done;
            if (pend == 0) begin
                mon_chk++;
                if (sck !== m_cpol) begin
                    mon_fail++;
                    $display("FAIL R3 idle sck actual=%0b expected=%0b", sck, m_cpol);
                end
            end
            if (sck !== prev_sck && pend > 0) begin
                lead = (sck != m_cpol);
                mon_chk++;
                if (lead && s_bit == 0) begin
                    if (cyc < m_div + 1) begin
                        mon_fail++;
                        $display("FAIL R12 gap actual=%0d expected>=%0d", cyc, m_div + 1);
                    end
                end else if (cyc != m_div + 1) begin
                    mon_fail++;
                    $display("FAIL R2 half period actual=%0d expected=%0d", cyc, m_div + 1);
                end
                if (lead) begin
                    if (!m_cpha) s_rx = m_lsb ? {mosi, s_rx[7:1]} : {s_rx[6:0], mosi};
                    else         s_out = s_bit;
                end else begin
                    if (m_cpha) s_rx = m_lsb ? {mosi, s_rx[7:1]} : {s_rx[6:0], mosi};
                    s_bit++;
                    if (!m_cpha) s_out = s_bit;
                    if (s_bit == 8) begin
                        capt[m_done] = s_rx;
                        m_done++;
                        s_bit = 0;
                        s_out = 0;
                    end
                end
                cyc = 0;
            end
            prev_sck = sck;
            tb = slv_byte(m_done);
            miso <= (s_out < 8) ? (m_lsb ? tb[s_out] : tb[7 - s_out]) : 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic send(input logic [7:0] b);
        wb[m_sent] = b;
        m_sent++;
        wr(3'd4, {8'h00, b});
    endtask

    task automatic wait_idle();
        logic [15:0] s;
        int guard = 0;
        do begin
            rd(3'd3, s);
            guard++;
        end while (!s[0] && guard < 3000);
    endtask

    task automatic cfg(input logic pol, input logic pha, input logic lsbf,
                       input int dv, input int lv, input logic en);
        wr(3'd0, 16'h0002);
        wr(3'd1, 16'((lv << 12) | (en << 3) | (lsbf << 2) | (pha << 1) | pol));
        m_cpol = pol; m_cpha = pha; m_lsb = lsbf; m_div = dv;
        wr(3'd2, {8'(dv), 8'h08});
        wr(3'd0, 16'h0001);
    endtask

    initial begin
        logic [15:0] r;
        int base;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        rd(3'd3, r); chk(r == 16'h0001, "R1 status after reset", r, 16'h0001);
        chk(irq == 1'b0, "R1 irq after reset", irq, 0);
        chk(sck == 1'b0, "R1 sck after reset", sck, 0);
        rd(3'd2, r); chk(r[3:0] == 4'd8, "R13 frame length field", r[3:0], 8);

        // R4 R5 R6 R2: all polarity/phase/order combinations
        for (int m = 0; m < 8; m++) begin
            base = m_sent;
            cfg(m[0], m[1], m[2], m % 3, 0, 1'b0);
            send(8'h3C + 8'(m * 17));
            rd(3'd3, r); chk(r[0] == 1'b0, "R8 busy after write", r[0], 0);
            send(8'hC3 ^ 8'(m));
            send(8'h81 + 8'(m));
            wait_idle();
            for (int k = 0; k < 3; k++) begin
                rd(3'd4, r);
                chk(r[7:0] == slv_byte(base + k), "R4 R5 R6 received byte", r[7:0], slv_byte(base + k));
                chk(capt[base + k] == wb[base + k], "R4 R5 R6 sent byte", capt[base + k], wb[base + k]);
            end
        end

        // R7: fill level 3 with interrupt
        base = m_sent;
        cfg(1'b0, 1'b0, 1'b0, 1, 2, 1'b1);
        send(8'h11); send(8'h22);
        wait_idle();
        rd(3'd3, r); chk(r == 16'h0009, "R7 two of three", r, 16'h0009);
        chk(irq == 1'b0, "R7 irq low below level", irq, 0);
        send(8'h33);
        wait_idle();
        rd(3'd3, r); chk(r == 16'h000B, "R7 level reached", r, 16'h000B);
        chk(irq == 1'b1, "R7 irq high", irq, 1);
        wr(3'd1, 16'h2000);
        @(negedge clk); #1;
        chk(irq == 1'b0, "R7 R11 enable cleared in run mode", irq, 0);
        for (int k = 0; k < 3; k++) begin
            rd(3'd4, r);
            chk(r[7:0] == slv_byte(base + k), "R6 R7 read back", r[7:0], slv_byte(base + k));
        end

        // R9 R12: push and pop in the same cycle, overflow, receive stall
        base = m_sent;
        cfg(1'b0, 1'b1, 1'b0, 0, 0, 1'b0);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (k < 5) begin
                wb[m_sent] = 8'h50 + 8'(k);
                m_sent++;
            end
            bus_wr = 1'b1; bus_addr = 3'd4; bus_wdata = {8'h00, 8'h50 + 8'(k)};
        end
        @(negedge clk);
        bus_wr = 1'b0;
        repeat (150) @(negedge clk);
        chk(m_done - base == 4, "R12 stall with receive queue full", m_done - base, 4);
        rd(3'd3, r); chk(r == 16'h000E, "R9 R12 status overflow and busy", r, 16'h000E);
        for (int k = 0; k < 4; k++) begin
            rd(3'd4, r);
            chk(r[7:0] == slv_byte(base + k), "R12 queued reply", r[7:0], slv_byte(base + k));
        end
        wait_idle();
        chk(m_done - base == 5, "R9 dropped word count", m_done - base, 5);
        rd(3'd4, r); chk(r[7:0] == slv_byte(base + 4), "R12 fifth reply", r[7:0], slv_byte(base + 4));
        for (int k = 0; k < 5; k++)
            chk(capt[base + k] == wb[base + k], "R9 R6 accepted order", capt[base + k], wb[base + k]);

        // R9 R10: sticky overflow, then flush
        send(8'h66); send(8'h77);
        wait_idle();
        rd(3'd3, r); chk(r == 16'h000F, "R9 overflow sticky", r, 16'h000F);
        wr(3'd0, 16'h0002);
        rd(3'd3, r); chk(r == 16'h0001, "R10 flush empties queues", r, 16'h0001);

        // R11: data ignored in configuration mode
        base = m_done;
        wr(3'd4, 16'h0099);
        wr(3'd0, 16'h0001);
        repeat (60) @(negedge clk);
        chk(m_done == base, "R11 config data write ignored", m_done, base);
        rd(3'd3, r); chk(r == 16'h0009, "R11 nothing queued", r, 16'h0009);

        // R11: control writes locked in run mode
        rd(3'd2, r);
        chk(r == 16'h0008, "R11 divisor before", r, 16'h0008);
        wr(3'd2, 16'h3308);
        rd(3'd2, r); chk(r == 16'h0008, "R11 divisor locked", r, 16'h0008);
        wr(3'd1, 16'h0007);
        rd(3'd1, r); chk(r[2:0] == 3'b010, "R11 framing bits locked", r[2:0], 3'b010);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_chk + mon_chk, n_fail + mon_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_chk + mon_chk + 1, n_fail + mon_fail + 1);
            $finish;
        end
    end
endmodule